// File: doc/BRIEF.md
# Fused Multiply-Add Product, Align and Add Core

This block is the arithmetic heart of a double-precision fused multiply-add unit. It takes two multiplicands and an accumulator that an upstream stage has already unpacked into sign, unbiased exponent and 53-bit significand with the hidden bit present. The multiplicands are finite and nonzero. The accumulator is either normalised or exactly zero, and zero is marked by an all-zero significand. The core returns the sum z + x*y, or z - x*y when the negate control is set. The result leaves as a sign, a signed exponent and a 56-bit significand that holds 53 value bits plus guard, round and sticky bits. Rounding and packing are left to a downstream stage.

The core keeps the full 106-bit product and folds only the discarded tail into a sticky bit before the single addition, so nothing is rounded midway. It is a three-stage pipeline. Stage one multiplies and reduces the product. Stage two aligns the product and the accumulator. Stage three adds or subtracts and then normalises. A valid flag travels alongside the data.

Top module: `fma_pa_core`

## Requirements
- R1: The product sign is x_sign XOR y_sign, inverted when negate_prod is 1. The product exponent is x_exp + y_exp.
- R2: The 106-bit product is cut to its top 56 bits with the leading one at bit 55. Every bit below that field is ORed into bit 0 (sticky).
- R3: When bit 105 of the product is set, the field is taken from bits 105..50 and the exponent rises by one. Otherwise it is taken from bits 104..49.
- R4: When z_sig is zero, the reduced product (sign, exponent, 56-bit field) is the output unchanged.
- R5: z_sig is extended with three zero low bits. The operand with the smaller exponent is shifted right by the exponent difference, all shifted-out bits are ORed into bit 0, and the shared exponent is the larger one. This holds for differences of any size.
- R6: With equal signs the fields are added. A carry out of bit 55 gives a one-bit right shift that keeps bit 0 sticky, and the exponent rises by one.
- R7: With differing signs the smaller field is subtracted from the larger, and the result takes the sign of the larger.
- R8: An exactly zero difference gives out_sig = 0 and out_exp = 0. out_sign equals round_down, so the zero is negative only toward minus infinity.
- R9: A nonzero difference is shifted left until bit 55 is set, and the exponent drops by one per position.
- R10: out_valid rises exactly three clock cycles after the in_valid that carried the operands. Reset clears all valid flags.
- R11: Exponents are 13-bit two's complement. Sums beyond the 11-bit double range, such as 2047 or -2044, appear without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| x_sign | input | 1 | Sign of multiplicand x |
| x_exp | input | 13 | Unbiased exponent of x, signed |
| x_sig | input | 53 | Significand of x, hidden bit at 52 |
| y_sign | input | 1 | Sign of multiplicand y |
| y_exp | input | 13 | Unbiased exponent of y, signed |
| y_sig | input | 53 | Significand of y, hidden bit at 52 |
| z_sign | input | 1 | Sign of accumulator z |
| z_exp | input | 13 | Unbiased exponent of z, signed |
| z_sig | input | 53 | Significand of z, zero means z = 0 |
| negate_prod | input | 1 | 1 selects z - x*y |
| round_down | input | 1 | Rounding is toward minus infinity |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | 13 | Result exponent, signed |
| out_sig | output | 56 | Result significand with guard, round, sticky |

## Verification
Most internal faults first show up as a wrong sticky bit 0 or a shifted exponent in the very vector that triggers them, three cycles after issue. A lost sticky during alignment leaves the field of a deep cancellation one unit high in its low bits. A bad leading-zero count moves out_exp and out_sig together in the same cycle. The bench compares every result against a bit-serial model of the arithmetic. Directed vectors target carry, exact cancellation in both rounding senses, very large alignment distances and exponents outside the 11-bit range.

// File: rtl/fma_dp_pkg.sv
package fma_dp_pkg;

    localparam int SIG_W    = 53;
    localparam int GRS_W    = 3;
    localparam int FLD_W    = SIG_W + GRS_W;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int EXP_W    = 13;
    localparam int SHAMT_W  = $clog2(FLD_W) + 2;
    localparam int LZ_W     = $clog2(FLD_W);
    localparam int SH_MAX   = (1 << SHAMT_W) - 1;

    localparam logic signed [EXP_W-1:0] EXP_ONE = EXP_W'(1);

    typedef struct packed {
        logic                    sign;
        logic signed [EXP_W-1:0] exp;
        logic [FLD_W-1:0]        sig;
    } fld_op_t;

    typedef struct packed {
        fld_op_t prod;
        fld_op_t acc;
        logic    acc_zero;
        logic    rdn;
    } red_stage_t;

    typedef struct packed {
        fld_op_t prod;
        fld_op_t acc;
        logic    acc_zero;
        logic    rdn;
    } aln_stage_t;

    // right shift that folds every lost bit into bit 0
    function automatic logic [FLD_W-1:0] shr_sticky(input logic [FLD_W-1:0] v,
                                                    input logic [SHAMT_W-1:0] sh);
        logic [FLD_W-1:0] keep_mask;
        logic [FLD_W-1:0] r;
        keep_mask = ~({FLD_W{1'b1}} << sh);
        r = v >> sh;
        r[0] = r[0] | (|(v & keep_mask));
        return r;
    endfunction

    // number of zeros above the leading one
    function automatic logic [LZ_W-1:0] lead_zeros(input logic [FLD_W-1:0] v);
        logic [LZ_W-1:0] n;
        n = '0;
        for (int i = 0; i < FLD_W; i++) begin
            if (v[i]) n = LZ_W'(FLD_W - 1 - i);
        end
        return n;
    endfunction

    // clamp an exponent gap magnitude to the shifter range
    function automatic logic [SHAMT_W-1:0] clamp_gap(input logic [EXP_W:0] mag);
        if (mag > (EXP_W+1)'(SH_MAX)) return SHAMT_W'(SH_MAX);
        return mag[SHAMT_W-1:0];
    endfunction

endpackage

// File: rtl/fma_prod_reduce.sv
module fma_prod_reduce
    import fma_dp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld_i,
    input  logic                    xs_i,
    input  logic signed [EXP_W-1:0] xe_i,
    input  logic [SIG_W-1:0]        xm_i,
    input  logic                    ys_i,
    input  logic signed [EXP_W-1:0] ye_i,
    input  logic [SIG_W-1:0]        ym_i,
    input  logic                    zs_i,
    input  logic signed [EXP_W-1:0] ze_i,
    input  logic [SIG_W-1:0]        zm_i,
    input  logic                    neg_i,
    input  logic                    rdn_i,
    output logic                    vld_o,
    output red_stage_t              st_o
);

    localparam int TAIL_W = PROD_W - FLD_W;

    logic [PROD_W-1:0]       full_prod;
    logic                    top_hit;
    logic [PROD_W-1:0]       lined_prod;
    logic [FLD_W-1:0]        prod_fld;
    logic signed [EXP_W-1:0] prod_exp;
    red_stage_t              st_d;

    always_comb begin
        full_prod  = {{SIG_W{1'b0}}, xm_i} * {{SIG_W{1'b0}}, ym_i};
        top_hit    = full_prod[PROD_W-1];
        lined_prod = top_hit ? full_prod : (full_prod << 1);
        prod_fld   = lined_prod[PROD_W-1 -: FLD_W];
        prod_fld[0] = prod_fld[0] | (|lined_prod[TAIL_W-1:0]);
        prod_exp   = xe_i + ye_i + (top_hit ? EXP_ONE : '0);

        st_d.prod.sign = xs_i ^ ys_i ^ neg_i;
        st_d.prod.exp  = prod_exp;
        st_d.prod.sig  = prod_fld;
        st_d.acc.sign  = zs_i;
        st_d.acc.exp   = ze_i;
        st_d.acc.sig   = {zm_i, {GRS_W{1'b0}}};
        st_d.acc_zero  = (zm_i == '0);
        st_d.rdn       = rdn_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
        if (vld_i) st_o <= st_d;
    end

    AST_PROD_LEAD: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> st_o.prod.sig[FLD_W-1]); // R2
    AST_STAGE1_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o); // R10

endmodule

// File: rtl/fma_align.sv
module fma_align
    import fma_dp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vld_i,
    input  red_stage_t st_i,
    output logic       vld_o,
    output aln_stage_t st_o
);

    logic signed [EXP_W:0] gap;
    logic [EXP_W:0]        gap_mag;
    logic [SHAMT_W-1:0]    sh_amt;
    aln_stage_t            st_d;

    always_comb begin
        gap     = $signed({st_i.acc.exp[EXP_W-1], st_i.acc.exp})
                - $signed({st_i.prod.exp[EXP_W-1], st_i.prod.exp});
        gap_mag = gap[EXP_W] ? (EXP_W+1)'(-gap) : (EXP_W+1)'(gap);
        sh_amt  = clamp_gap(gap_mag);

        st_d.prod     = st_i.prod;
        st_d.acc      = st_i.acc;
        st_d.acc_zero = st_i.acc_zero;
        st_d.rdn      = st_i.rdn;

        if (!st_i.acc_zero) begin
            if (gap > 0) begin
                st_d.prod.sig = shr_sticky(st_i.prod.sig, sh_amt);
                st_d.prod.exp = st_i.acc.exp;
            end else if (gap < 0) begin
                st_d.acc.sig = shr_sticky(st_i.acc.sig, sh_amt);
                st_d.acc.exp = st_i.prod.exp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
        if (vld_i) st_o <= st_d;
    end

    AST_ALIGN_LEAD: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !st_o.acc_zero) |-> (st_o.acc.sig[FLD_W-1] || st_o.prod.sig[FLD_W-1])); // R5
    AST_ALIGN_EXP: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !st_o.acc_zero) |-> (st_o.acc.exp == st_o.prod.exp)); // R5
    AST_STAGE2_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o); // R10

endmodule

// File: rtl/fma_addnorm.sv
module fma_addnorm
    import fma_dp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vld_i,
    input  aln_stage_t st_i,
    output logic       vld_o,
    output fld_op_t    res_o
);

    logic [FLD_W:0]   sum_w;
    logic             acc_ge;
    logic [FLD_W-1:0] diff;
    logic [LZ_W-1:0]  lz;
    fld_op_t          res_d;

    always_comb begin
        sum_w  = {1'b0, st_i.acc.sig} + {1'b0, st_i.prod.sig};
        acc_ge = (st_i.acc.sig >= st_i.prod.sig);
        diff   = acc_ge ? (st_i.acc.sig - st_i.prod.sig) : (st_i.prod.sig - st_i.acc.sig);
        lz     = lead_zeros(diff);
        res_d  = st_i.prod;

        if (st_i.acc_zero) begin
            res_d = st_i.prod;
        end else if (st_i.acc.sign == st_i.prod.sign) begin
            res_d.sign = st_i.acc.sign;
            if (sum_w[FLD_W]) begin
                res_d.sig    = sum_w[FLD_W:1];
                res_d.sig[0] = sum_w[1] | sum_w[0];
                res_d.exp    = st_i.acc.exp + EXP_ONE;
            end else begin
                res_d.sig = sum_w[FLD_W-1:0];
                res_d.exp = st_i.acc.exp;
            end
        end else if (diff == '0) begin
            res_d.sign = st_i.rdn;
            res_d.exp  = '0;
            res_d.sig  = '0;
        end else begin
            res_d.sign = acc_ge ? st_i.acc.sign : st_i.prod.sign;
            res_d.sig  = diff << lz;
            res_d.exp  = st_i.acc.exp - $signed({{(EXP_W-LZ_W){1'b0}}, lz});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
        if (vld_i) res_o <= res_d;
    end

    AST_NORM_LEAD: assert property (@(posedge clk) disable iff (rst)
        (vld_o && res_o.sig != '0) |-> res_o.sig[FLD_W-1]); // R9
    AST_ZERO_FORM: assert property (@(posedge clk) disable iff (rst)
        (vld_o && res_o.sig == '0) |-> (res_o.exp == '0)); // R8
    AST_STAGE3_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o); // R10

endmodule

// File: rtl/fma_pa_core.sv
module fma_pa_core
    import fma_dp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    x_sign,
    input  logic signed [EXP_W-1:0] x_exp,
    input  logic [SIG_W-1:0]        x_sig,
    input  logic                    y_sign,
    input  logic signed [EXP_W-1:0] y_exp,
    input  logic [SIG_W-1:0]        y_sig,
    input  logic                    z_sign,
    input  logic signed [EXP_W-1:0] z_exp,
    input  logic [SIG_W-1:0]        z_sig,
    input  logic                    negate_prod,
    input  logic                    round_down,
    output logic                    out_valid,
    output logic                    out_sign,
    output logic signed [EXP_W-1:0] out_exp,
    output logic [FLD_W-1:0]        out_sig
);

    logic       red_vld;
    red_stage_t red_st;
    logic       aln_vld;
    aln_stage_t aln_st;
    fld_op_t    res;

    fma_prod_reduce u_reduce (
        .clk   (clk),
        .rst   (rst),
        .vld_i (in_valid),
        .xs_i  (x_sign),
        .xe_i  (x_exp),
        .xm_i  (x_sig),
        .ys_i  (y_sign),
        .ye_i  (y_exp),
        .ym_i  (y_sig),
        .zs_i  (z_sign),
        .ze_i  (z_exp),
        .zm_i  (z_sig),
        .neg_i (negate_prod),
        .rdn_i (round_down),
        .vld_o (red_vld),
        .st_o  (red_st)
    );

    fma_align u_align (
        .clk   (clk),
        .rst   (rst),
        .vld_i (red_vld),
        .st_i  (red_st),
        .vld_o (aln_vld),
        .st_o  (aln_st)
    );

    fma_addnorm u_addnorm (
        .clk   (clk),
        .rst   (rst),
        .vld_i (aln_vld),
        .st_i  (aln_st),
        .vld_o (out_valid),
        .res_o (res)
    );

    assign out_sign = res.sign;
    assign out_exp  = res.exp;
    assign out_sig  = res.sig;

    AST_OUT_NOT_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(aln_vld)); // R10

endmodule

// File: tb/fma_pa_core_tb_top.sv
module fma_pa_core_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic               in_valid = 1'b0;
    logic               x_sign = 0, y_sign = 0, z_sign = 0;
    logic signed [12:0] x_exp = '0, y_exp = '0, z_exp = '0;
    logic [52:0]        x_sig = '0, y_sig = '0, z_sig = '0;
    logic               negate_prod = 0, round_down = 0;
    logic               out_valid;
    logic               out_sign;
    logic signed [12:0] out_exp;
    logic [55:0]        out_sig;

    fma_pa_core dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x_sign(x_sign), .x_exp(x_exp), .x_sig(x_sig),
        .y_sign(y_sign), .y_exp(y_exp), .y_sig(y_sig),
        .z_sign(z_sign), .z_exp(z_exp), .z_sig(z_sig),
        .negate_prod(negate_prod), .round_down(round_down),
        .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    bit          q_sign[$];
    int          q_exp[$];
    logic [55:0] q_sig[$];
    string       q_tag[$];
    int          q_cyc[$];

    localparam logic [52:0] ONE  = 53'h10_0000_0000_0000;
    localparam logic [52:0] ONEH = 53'h18_0000_0000_0000;

    always @(posedge clk) cyc <= cyc + 1;

    // bit-serial model of the arithmetic stated in the requirements
    function automatic void ref_model(input bit xs, ys, zs, neg, rdn,
                                      input int xe, ye, ze,
                                      input logic [52:0] xm, ym, zm,
                                      output bit os, output int oe, output logic [55:0] osig);
        logic [105:0] p;
        logic [55:0]  pf, zf, d;
        logic [56:0]  s;
        bit st;
        int k, pe, zx;
        p = 106'(xm) * 106'(ym);
        st = 0; k = 0;
        while ((p >> 56) != 0) begin
            st = st | p[0];
            p = p >> 1;
            k++;
        end
        pf = p[55:0];
        pf[0] = pf[0] | st;
        pe = xe + ye + k - 49;
        os = xs ^ ys ^ neg;
        if (zm == 0) begin
            oe = pe; osig = pf; return;
        end
        zf = {zm, 3'b000};
        zx = ze;
        while (zx < pe) begin zf = (zf >> 1) | (zf & 56'd1); zx++; end
        while (pe < zx) begin pf = (pf >> 1) | (pf & 56'd1); pe++; end
        if (zs == os) begin
            s = 57'(zf) + 57'(pf);
            oe = zx;
            if (s[56]) begin s = (s >> 1) | (s & 57'd1); oe++; end
            os = zs; osig = s[55:0];
        end else begin
            if (zf >= pf) begin d = zf - pf; os = zs; end
            else          begin d = pf - zf; end
            oe = zx;
            if (d == 0) begin
                os = rdn; oe = 0; osig = '0;
            end else begin
                while (!d[55]) begin d = d << 1; oe--; end
                osig = d;
            end
        end
    endfunction

    task automatic apply(input bit xs, ys, zs, neg, rdn, input int xe, ye, ze,
                         input logic [52:0] xm, ym, zm,
                         input string tag, input bit es, input int ee, input logic [55:0] esig);
        @(negedge clk);
        in_valid = 1; x_sign = xs; y_sign = ys; z_sign = zs;
        x_exp = 13'(xe); y_exp = 13'(ye); z_exp = 13'(ze);
        x_sig = xm; y_sig = ym; z_sig = zm;
        negate_prod = neg; round_down = rdn;
        q_sign.push_back(es); q_exp.push_back(ee); q_sig.push_back(esig);
        q_tag.push_back(tag); q_cyc.push_back(cyc);
    endtask

    task automatic apply_ref(input bit xs, ys, zs, neg, rdn, input int xe, ye, ze,
                             input logic [52:0] xm, ym, zm, input string tag);
        bit es; int ee; logic [55:0] esig;
        ref_model(xs, ys, zs, neg, rdn, xe, ye, ze, xm, ym, zm, es, ee, esig);
        apply(xs, ys, zs, neg, rdn, xe, ye, ze, xm, ym, zm, tag, es, ee, esig);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done && out_valid) begin
            n_vec++;
            if (q_sig.size() == 0) begin
                n_bad++;
                $display("FAIL R10: result with nothing issued, actual sig %h expected none", out_sig);
            end else begin
                bit es; int ee; logic [55:0] esig; string tg; int c0;
                es = q_sign.pop_front(); ee = q_exp.pop_front(); esig = q_sig.pop_front();
                tg = q_tag.pop_front(); c0 = q_cyc.pop_front();
                if (out_sign !== es || int'(out_exp) != ee || out_sig !== esig) begin
                    n_bad++;
                    $display("FAIL %s: actual s=%0d e=%0d m=%h expected s=%0d e=%0d m=%h",
                             tg, out_sign, int'(out_exp), out_sig, es, ee, esig);
                end
                if (cyc - c0 != 3) begin
                    n_bad++;
                    $display("FAIL R10: latency actual %0d expected 3", cyc - c0);
                end
            end
        end
    end

    initial begin : watchdog
        wait (cyc > 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R10: watchdog expired, actual %0d cycles expected fewer", cyc);
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: out_valid in reset actual %0d expected 0", out_valid);
        end
        rst = 0;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: out_valid after reset actual %0d expected 0", out_valid);
        end

        // R1 R4: sign xor, exponent sum, zero accumulator
        apply(1, 0, 0, 0, 0, 3, -5, 0, ONE, ONE, '0, "R1_R4 product pass", 1, -2, 56'h80_0000_0000_0000);
        idle(); idle(); idle();
        apply(1, 0, 0, 1, 0, 3, -5, 0, ONE, ONE, '0, "R1 negate", 0, -2, 56'h80_0000_0000_0000);
        // R3: top product bit set
        apply(0, 0, 0, 0, 0, 0, 0, 0, ONEH, ONEH, '0, "R3 top bit", 0, 1, 56'h90_0000_0000_0000);
        // R2: sticky from the discarded tail
        apply(0, 0, 0, 0, 0, 0, 0, 0, {53{1'b1}}, {53{1'b1}}, '0, "R2 sticky", 0, 1, 56'hFF_FFFF_FFFF_FFF1);
        // R6: carry on addition
        apply(0, 0, 0, 0, 0, 0, 0, 0, ONE, ONE, ONE, "R6 carry", 0, 1, 56'h80_0000_0000_0000);
        // R8: exact zero in both rounding senses
        apply(0, 0, 1, 0, 0, 0, 0, 0, ONE, ONE, ONE, "R8 zero plus", 0, 0, '0);
        apply(0, 0, 1, 0, 1, 0, 0, 0, ONE, ONE, ONE, "R8 zero minus", 1, 0, '0);
        apply(0, 0, 0, 1, 1, 0, 0, 0, ONE, ONE, ONE, "R8 negate zero", 1, 0, '0);
        // R5 R9: deep cancellation with sticky
        apply(1, 0, 0, 0, 0, -60, 0, 0, ONE, ONE, ONE, "R5_R9 cancel sticky", 0, -1, 56'hFF_FFFF_FFFF_FFFE);
        // R7: product larger, result takes its sign
        apply(1, 0, 0, 0, 0, 0, 0, 0, ONEH, ONE, ONE, "R7 larger product", 1, -1, 56'h80_0000_0000_0000);
        // R5: accumulator shifted
        apply(0, 0, 0, 0, 0, 0, 0, -2, ONE, ONE, ONE, "R5 acc shift", 0, 0, 56'hA0_0000_0000_0000);
        // R5: huge gap
        apply(1, 0, 0, 0, 0, 0, 0, 1000, ONE, ONE, ONE, "R5 huge gap", 0, 999, 56'hFF_FFFF_FFFF_FFFE);
        // R11: exponents outside the 11-bit range
        apply(0, 0, 0, 0, 0, 1023, 1023, 0, ONEH, ONEH, '0, "R11 high exp", 0, 2047, 56'h90_0000_0000_0000);
        apply(0, 0, 0, 0, 0, -1022, -1022, 0, ONE, ONE, '0, "R11 low exp", 0, -2044, 56'h80_0000_0000_0000);
        idle();

        // random traffic: R5 R6 R7 R9 mixes
        for (int i = 0; i < 600; i++) begin
            logic [52:0] xm, ym, zm;
            int xe, ye, ze, mode;
            bit zs;
            xm = {1'b1, 20'($urandom()), $urandom()};
            ym = {1'b1, 20'($urandom()), $urandom()};
            zm = {1'b1, 20'($urandom()), $urandom()};
            xe = int'($urandom_range(160)) - 80;
            ye = int'($urandom_range(160)) - 80;
            ze = int'($urandom_range(360)) - 180;
            zs = 1'($urandom());
            mode = int'($urandom_range(7));
            if (mode == 0) zm = '0;
            if (mode >= 5) begin
                ze = xe + ye + int'($urandom_range(1));
                if (mode == 7) begin zm = ym; ze = xe + ye; xm = ONE; end
            end
            apply_ref(1'($urandom()), 1'($urandom()), zs, 1'($urandom()), 1'($urandom()),
                      xe, ye, ze, xm, ym, zm, "R5_R6_R7_R9 random");
            if ($urandom_range(3) == 0) idle();
        end
        idle();
        repeat (8) @(negedge clk);
        n_vec++;
        if (q_sig.size() != 0) begin
            n_bad++;
            $display("FAIL R10: results missing, actual %0d pending expected 0", q_sig.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule